// File: doc/BRIEF.md
# Pipeline Interlock for Integer Core with Multiplier

This block is the purely combinational interlock of an in-order, fully bypassed integer pipeline with fetch, decode, execute, memory and write-back stages, and a separate three-stage multiply pipe. A multiply leaves decode into its own pipe (MUL1, MUL2, MUL3) rather than into execute. It writes back one cycle after the last multiply stage. Every other instruction goes through execute and memory. Operands are needed when an instruction enters execute or MUL1. An ALU result is forwarded at the end of execute, a load at the end of memory, and a product at the end of MUL3.

From the opcode and register fields of the instructions in decode, execute, MUL1 and MUL2, the block works out which registers each stage writes and reads. It raises one stall that freezes fetch and decode. It also steers the decode instruction into execute or MUL1. When nothing is issued, the stage left empty receives a NOP. The stall covers three cases:

- a load whose data is not yet ready for the instruction in decode;
- a multiply product that is not yet ready for that instruction;
- the case where issuing a non-multiply would make it share the write-back cycle with an older multiply, or retire ahead of it.

Top module: `pipe_interlock`

## Requirements
- R1: Opcodes are 4 bits: 0 NOP, 1 ALU, 2 ALUI, 3 LW, 4 SW, 5 IMUL, 6 BZ, 7 J, 8 JAL, 9 JR, 10 JALR. Codes 11 to 15 act as NOP: they read nothing, write nothing, are never issued and never cause a stall.
- R2: The first source field is read for ALU, ALUI, LW, SW, IMUL, BZ, JR and JALR. The second source field is read only for ALU, SW and IMUL. A field that is not read never causes a stall.
- R3: The destination is the third field for ALU and IMUL, and the second field for ALUI and LW. A destination of register 0 never causes a stall.
- R4: A load in execute whose destination equals a source read by decode stalls.
- R5: A multiply in MUL1 or MUL2 whose destination equals a source read by decode stalls.
- R6: An instruction in execute that is not a load never stalls decode, even when its destination matches a source.
- R7: Any valid non-multiply in decode stalls while a multiply occupies MUL1. A multiply in MUL2 alone causes no such stall.
- R8: A multiply in decode behind a multiply in MUL1 with no register match is not stalled.
- R9: Without a stall, a valid multiply in decode raises issue_mul_o and any other valid op raises issue_alu_o. During a stall, or for a NOP, neither is raised, so both execute and MUL1 receive a NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_op_i | input | 4 | opcode in decode |
| d_rf1_i | input | 5 | first register field in decode |
| d_rf2_i | input | 5 | second register field in decode |
| e_op_i | input | 4 | opcode in execute |
| e_rf2_i | input | 5 | second register field in execute |
| e_rf3_i | input | 5 | third register field in execute |
| mul1_op_i | input | 4 | opcode in MUL1 |
| mul1_rf2_i | input | 5 | second register field in MUL1 |
| mul1_rf3_i | input | 5 | third register field in MUL1 |
| mul2_op_i | input | 4 | opcode in MUL2 |
| mul2_rf2_i | input | 5 | second register field in MUL2 |
| mul2_rf3_i | input | 5 | third register field in MUL2 |
| stall_o | output | 1 | freeze fetch and decode |
| issue_alu_o | output | 1 | decode enters execute this cycle |
| issue_mul_o | output | 1 | decode enters MUL1 this cycle |

## Verification
The assertions take for granted that every input is a known value once the pipeline runs, and they skip evaluation while any output is unknown. They accept any opcode code in any stage, including a non-multiply in a multiply stage, because the block qualifies each producer by its own opcode. The stimulus drives all fields to zero before the first check. It then mixes directed cases with random opcodes over all sixteen codes and register numbers drawn mostly from a small set, so that register matches, register 0 and the reserved codes occur often.

// File: rtl/pipe_interlock_pkg.sv
package pipe_interlock_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 4'd0,
    OP_ALU  = 4'd1,
    OP_ALUI = 4'd2,
    OP_LW   = 4'd3,
    OP_SW   = 4'd4,
    OP_IMUL = 4'd5,
    OP_BZ   = 4'd6,
    OP_J    = 4'd7,
    OP_JAL  = 4'd8,
    OP_JR   = 4'd9,
    OP_JALR = 4'd10
  } op_e;

  localparam int unsigned N_PROD = 3;  // execute, MUL1, MUL2
endpackage

// File: rtl/pipe_interlock_dst.sv
module pipe_interlock_dst
  import pipe_interlock_pkg::*;
#(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned LINK_REG = 31
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [REG_W-1:0] rf2_i,
  input  logic [REG_W-1:0] rf3_i,
  output logic             we_o,
  output logic [REG_W-1:0] ws_o
);
  logic wr;

  always_comb begin
    wr   = 1'b1;
    ws_o = '0;
    case (op_e'(op_i))
      OP_ALU, OP_IMUL:  ws_o = rf3_i;
      OP_ALUI, OP_LW:   ws_o = rf2_i;
      OP_JAL, OP_JALR:  ws_o = REG_W'(LINK_REG);
      default:          wr   = 1'b0;
    endcase
    we_o = wr && (ws_o != '0);
  end

  always_comb begin
    if (!$isunknown({op_i, we_o}))
      p_nop_no_write_r1: assert (!((op_i == OP_NOP || op_i > OP_JALR) && we_o))
        else $error("reserved or NOP opcode asserts write enable");
  end
endmodule

// File: rtl/pipe_interlock_src.sv
module pipe_interlock_src
  import pipe_interlock_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            re1_o,
  output logic            re2_o
);
  always_comb begin
    re1_o = 1'b0;
    re2_o = 1'b0;
    case (op_e'(op_i))
      OP_ALU, OP_SW, OP_IMUL: begin
        re1_o = 1'b1;
        re2_o = 1'b1;
      end
      OP_ALUI, OP_LW, OP_BZ, OP_JR, OP_JALR: re1_o = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, re1_o, re2_o}))
      p_no_read_r2: assert (!((op_i == OP_J || op_i == OP_JAL || op_i == OP_NOP) && (re1_o || re2_o)))
        else $error("jump or NOP reads a source");
  end
endmodule

// File: rtl/pipe_interlock_match.sv
module pipe_interlock_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic             qual_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] ws_i,
  input  logic             re1_i,
  input  logic             re2_i,
  input  logic [REG_W-1:0] rf1_i,
  input  logic [REG_W-1:0] rf2_i,
  output logic             hit_o
);
  always_comb
    hit_o = qual_i && we_i && ((re1_i && (ws_i == rf1_i)) || (re2_i && (ws_i == rf2_i)));

  always_comb begin
    if (!$isunknown({hit_o, ws_i}))
      p_r0_quiet_r3: assert (!(hit_o && ws_i == '0))
        else $error("register 0 destination raised a hazard");
  end
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pipe_interlock_pkg::*;
#(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned LINK_REG = 31
) (
  input  logic [OP_W-1:0]  d_op_i,
  input  logic [REG_W-1:0] d_rf1_i,
  input  logic [REG_W-1:0] d_rf2_i,
  input  logic [OP_W-1:0]  e_op_i,
  input  logic [REG_W-1:0] e_rf2_i,
  input  logic [REG_W-1:0] e_rf3_i,
  input  logic [OP_W-1:0]  mul1_op_i,
  input  logic [REG_W-1:0] mul1_rf2_i,
  input  logic [REG_W-1:0] mul1_rf3_i,
  input  logic [OP_W-1:0]  mul2_op_i,
  input  logic [REG_W-1:0] mul2_rf2_i,
  input  logic [REG_W-1:0] mul2_rf3_i,
  output logic             stall_o,
  output logic             issue_alu_o,
  output logic             issue_mul_o
);
  logic [OP_W-1:0]  p_op   [N_PROD];
  logic [REG_W-1:0] p_rf2  [N_PROD];
  logic [REG_W-1:0] p_rf3  [N_PROD];
  op_e              p_late [N_PROD];  // producer kind whose result is late
  logic [N_PROD-1:0] p_hit;
  logic d_re1, d_re2, d_valid, d_mul, wb_clash;

  always_comb begin
    p_op[0] = e_op_i;    p_rf2[0] = e_rf2_i;    p_rf3[0] = e_rf3_i;    p_late[0] = OP_LW;
    p_op[1] = mul1_op_i; p_rf2[1] = mul1_rf2_i; p_rf3[1] = mul1_rf3_i; p_late[1] = OP_IMUL;
    p_op[2] = mul2_op_i; p_rf2[2] = mul2_rf2_i; p_rf3[2] = mul2_rf3_i; p_late[2] = OP_IMUL;
  end

  pipe_interlock_src u_src (
    .op_i  (d_op_i),
    .re1_o (d_re1),
    .re2_o (d_re2)
  );

  for (genvar g = 0; g < N_PROD; g++) begin : g_prod
    logic             we;
    logic [REG_W-1:0] ws;

    pipe_interlock_dst #(.REG_W(REG_W), .LINK_REG(LINK_REG)) u_dst (
      .op_i  (p_op[g]),
      .rf2_i (p_rf2[g]),
      .rf3_i (p_rf3[g]),
      .we_o  (we),
      .ws_o  (ws)
    );

    pipe_interlock_match #(.REG_W(REG_W)) u_match (
      .qual_i (p_op[g] == p_late[g]),
      .we_i   (we),
      .ws_i   (ws),
      .re1_i  (d_re1),
      .re2_i  (d_re2),
      .rf1_i  (d_rf1_i),
      .rf2_i  (d_rf2_i),
      .hit_o  (p_hit[g])
    );
  end

  always_comb begin
    d_valid  = (d_op_i != OP_NOP) && (d_op_i <= OP_JALR);
    d_mul    = (d_op_i == OP_IMUL);
    // a non-multiply issued now would reach write-back with the MUL1 product
    wb_clash = d_valid && !d_mul && (mul1_op_i == OP_IMUL);
    stall_o     = d_valid && ((|p_hit) || wb_clash);
    issue_alu_o = d_valid && !stall_o && !d_mul;
    issue_mul_o = d_valid && !stall_o && d_mul;
  end

  always_comb begin
    if (!$isunknown({stall_o, issue_alu_o, issue_mul_o, d_op_i, mul1_op_i})) begin
      p_one_issue_r9: assert (!(issue_alu_o && issue_mul_o))
        else $error("decode issued to both pipes");
      p_stall_no_issue_r9: assert (!(stall_o && (issue_alu_o || issue_mul_o)))
        else $error("issue during stall");
      p_wb_order_r7: assert (!(mul1_op_i == OP_IMUL && issue_alu_o))
        else $error("non-multiply issued beside a MUL1 multiply");
      p_nop_idle_r1: assert (!(d_op_i == OP_NOP && (stall_o || issue_alu_o || issue_mul_o)))
        else $error("NOP in decode stalled or issued");
    end
  end
endmodule

// File: tb/sim_pipe_interlock.sv
module sim_pipe_interlock;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] d_op = '0, e_op = '0, m1_op = '0, m2_op = '0;
  logic [4:0] d_r1 = '0, d_r2 = '0, e_r2 = '0, e_r3 = '0;
  logic [4:0] m1_r2 = '0, m1_r3 = '0, m2_r2 = '0, m2_r3 = '0;
  logic stall, iss_alu, iss_mul;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_interlock u0 (
    .d_op_i(d_op), .d_rf1_i(d_r1), .d_rf2_i(d_r2),
    .e_op_i(e_op), .e_rf2_i(e_r2), .e_rf3_i(e_r3),
    .mul1_op_i(m1_op), .mul1_rf2_i(m1_r2), .mul1_rf3_i(m1_r3),
    .mul2_op_i(m2_op), .mul2_rf2_i(m2_r2), .mul2_rf3_i(m2_r3),
    .stall_o(stall), .issue_alu_o(iss_alu), .issue_mul_o(iss_mul)
  );

  // behavioural reference
  function automatic int dest_of(int op, int r2, int r3);
    int d;
    if (op == 1 || op == 5) d = r3;
    else if (op == 2 || op == 3) d = r2;
    else if (op == 8 || op == 10) d = 31;
    else return -1;
    return (d == 0) ? -1 : d;
  endfunction

  function automatic bit reads_a(int op);
    return op inside {1, 2, 3, 4, 5, 6, 9, 10};
  endfunction

  function automatic bit reads_b(int op);
    return op inside {1, 4, 5};
  endfunction

  function automatic bit needs(int dst);
    if (dst < 0) return 1'b0;
    return (reads_a(int'(d_op)) && int'(d_r1) == dst) || (reads_b(int'(d_op)) && int'(d_r2) == dst);
  endfunction

  function automatic logic [2:0] model();
    bit valid, st;
    valid = (d_op >= 1 && d_op <= 10);
    st = 1'b0;
    if (e_op == 3 && needs(dest_of(e_op, e_r2, e_r3))) st = 1'b1;
    if (m1_op == 5 && needs(dest_of(m1_op, m1_r2, m1_r3))) st = 1'b1;
    if (m2_op == 5 && needs(dest_of(m2_op, m2_r2, m2_r3))) st = 1'b1;
    if (m1_op == 5 && d_op != 5) st = 1'b1;
    st = st && valid;
    return {st, valid && !st && d_op != 5, valid && !st && d_op == 5};
  endfunction

  task automatic drive(int dop, int dr1, int dr2, int eop, int er2, int er3,
                       int aop, int ar2, int ar3, int bop, int br2, int br3);
    @(posedge clk);
    d_op <= 4'(dop); d_r1 <= 5'(dr1); d_r2 <= 5'(dr2);
    e_op <= 4'(eop); e_r2 <= 5'(er2); e_r3 <= 5'(er3);
    m1_op <= 4'(aop); m1_r2 <= 5'(ar2); m1_r3 <= 5'(ar3);
    m2_op <= 4'(bop); m2_r2 <= 5'(br2); m2_r3 <= 5'(br3);
    @(negedge clk);
  endtask

  task automatic expect3(string tag, logic [2:0] exp);
    checks++;
    if ({stall, iss_alu, iss_mul} !== exp) begin
      fails++;
      $display("FAIL %s stall/alu/mul actual=%b expected=%b", tag, {stall, iss_alu, iss_mul}, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_ni <= 1'b1;
    @(negedge clk);
    expect3("R1 idle after reset", 3'b000);

    drive(1, 1, 2,  3, 2, 0,  0, 0, 0,  0, 0, 0);  expect3("R4 load-use on rf2", 3'b100);
    drive(2, 3, 2,  3, 2, 0,  0, 0, 0,  0, 0, 0);  expect3("R2 ALUI second field unread", 3'b010);
    drive(1, 0, 0,  3, 0, 0,  0, 0, 0,  0, 0, 0);  expect3("R3 load to r0", 3'b010);
    drive(4, 1, 4,  1, 0, 4,  0, 0, 0,  0, 0, 0);  expect3("R6 ALU in execute", 3'b010);
    drive(1, 6, 1,  0, 0, 0,  0, 0, 0,  5, 0, 6);  expect3("R5 product in MUL2", 3'b100);
    drive(5, 7, 1,  0, 0, 0,  5, 0, 7,  0, 0, 0);  expect3("R5 product in MUL1", 3'b100);
    drive(5, 1, 2,  0, 0, 0,  5, 0, 9,  0, 0, 0);  expect3("R8 back-to-back multiply", 3'b001);
    drive(4, 1, 2,  0, 0, 0,  5, 0, 9,  0, 0, 0);  expect3("R7 write-back clash", 3'b100);
    drive(1, 1, 2,  0, 0, 0,  0, 0, 0,  5, 0, 9);  expect3("R7 MUL2 no clash", 3'b010);
    drive(12, 2, 2, 3, 2, 0,  5, 0, 2,  0, 0, 0);  expect3("R1 reserved opcode", 3'b000);
    drive(7, 2, 2,  3, 2, 0,  0, 0, 0,  0, 0, 0);  expect3("R2 jump reads nothing", 3'b010);
    drive(5, 0, 1,  0, 0, 0,  5, 0, 0,  0, 0, 0);  expect3("R3 multiply to r0", 3'b001);
    drive(6, 4, 1,  0, 0, 0,  0, 0, 0,  5, 0, 4);  expect3("R5 branch first source", 3'b100);
    drive(6, 1, 4,  0, 0, 0,  0, 0, 0,  5, 0, 4);  expect3("R2 branch second field unread", 3'b010);
    drive(0, 1, 1,  3, 1, 0,  5, 0, 1,  5, 0, 1);  expect3("R9 NOP never issues", 3'b000);

    for (int i = 0; i < 3000; i++) begin
      int pick;
      pick = $urandom_range(0, 9);
      drive($urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 15), (pick == 0) ? $urandom_range(0, 31) : $urandom_range(0, 3),
            $urandom_range(0, 3),
            (pick < 5) ? 5 : $urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 3),
            (pick > 4) ? 5 : $urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 3));
      expect3("random R4 R5 R7 R9", model());
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule